// File: doc/BRIEF.md
# Serial Transmitter with Line-Break Control

This block is the transmit half of one asynchronous serial channel. A host loads characters one at a time into a single holding register. From there each character passes to a shift register, which sends it as a frame on the serial line. A 16x oversampling enable sets the pace, and every bit lasts sixteen of its pulses. Character length, parity and stop-bit count are fixed at build time. The serial line rests at mark (high) whenever nothing is being sent.

The host steers the transmitter through a one-cycle command port. The commands are enable, disable, reset, start break and stop break. Two status outputs report progress: one says the holding register can take a character, the other says the transmitter has run dry. Disable and start break both let queued characters drain first. Stop break ends the spacing condition on a bit boundary and then guarantees a full bit of mark before the next character goes out.

Top module: `sertx_brk`

## Requirements
- R1: After power-on reset, `txd` is 1 and `tx_ready` and `tx_empty` are 0. The transmitter starts out disabled.
- R2: Frame format, in time order: a start bit of 0, then DATA_BITS data bits with the least significant bit first, then one parity bit (even parity with the default PARITY_ODD=0, so the parity bit equals the XOR of the data bits), then STOP_BITS stop bits of 1. Every bit lasts OS_RATE pulses of `tick16`.
- R3: An enable command from the disabled state sets both `tx_ready` and `tx_empty`. Writes made while disabled are dropped and never transmitted.
- R4: An accepted write clears `tx_ready` on the next cycle. `tx_ready` returns when the character moves to the shift register, which happens in the same cycle that its start bit appears. `tx_empty` is set once the last stop bit is done with nothing waiting. `tx_empty` never stands without `tx_ready`.
- R5: A write while `tx_ready` is 0 is ignored.
- R6: A disable clears `tx_ready` and `tx_empty` on the next cycle. Any character in the shift or holding register is still sent in full. After that the transmitter is inactive and ignores writes.
- R7: A command word that carries both enable and disable acts as a disable.
- R8: Start break is accepted only while the transmitter is enabled and no disable is pending. When the transmitter is idle, `txd` goes to 0 within one bit time and stays there.
- R9: If start break arrives while characters are queued or in flight, those characters are sent complete. The break begins at the end of the last stop bit.
- R10: Stop break returns `txd` to 1 within one bit time. `txd` then stays at 1 for at least one full bit time before the next start bit.
- R11: The reset command sets `txd` to 1 on the next cycle, clears `tx_ready` and `tx_empty`, discards the held character and any break, and leaves the transmitter disabled.
- R12: `txd` changes only on the cycle after a bit boundary or after a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Oversampling enable, OS_RATE pulses per bit |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_BITS | Character to send |
| cmd_valid | input | 1 | Command word present this cycle |
| cmd_enable | input | 1 | Enable transmitter |
| cmd_disable | input | 1 | Disable transmitter (deferred until drained) |
| cmd_reset | input | 1 | Reset transmitter |
| cmd_brk_start | input | 1 | Start break |
| cmd_brk_stop | input | 1 | Stop break |
| txd | output | 1 | Serial output, 1 = mark |
| tx_ready | output | 1 | Holding register empty and transmitter accepting |
| tx_empty | output | 1 | Nothing held and nothing shifting |

## Verification
Status changes from a write or a command are due on the first cycle after the edge that samples them. The bench drives on falling edges and reads on the next falling edge. Serial timing hangs on the free-running bit boundary: a start bit, the start of a break or the end of a break lands within OS_RATE pulses of `tick16` (32 clocks here). The bench therefore waits for an edge on `txd` inside a bounded window and then reads each bit at its centre, 16 clocks in. The length of the mark gap after a break is measured in clocks from the rising edge to the following start bit. A background monitor counts its own `tick16` pulses and flags any edge on `txd` that follows neither a bit boundary nor a command.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  // Parity over the low n bits of d; odd selects odd parity.
  function automatic logic par_bit(input logic [15:0] d, input int n, input logic odd);
    logic p;
    p = odd;
    for (int i = 0; i < 16; i++) begin
      if (i < n) p = p ^ d[i];
    end
    return p;
  endfunction

endpackage

// File: rtl/sertx_bitclk.sv
module sertx_bitclk #(
  parameter int OS_RATE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick16,
  output logic bit_stb
);
  localparam int CW = (OS_RATE > 1) ? $clog2(OS_RATE) : 1;
  localparam logic [CW-1:0] LAST = CW'(OS_RATE - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (tick16) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign bit_stb = tick16 && (cnt == LAST);
endmodule

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic         clr,
  input  logic         take,
  input  logic [W-1:0] din,
  output logic         full,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      dout <= '0;
    end else if (clr) begin
      full <= 1'b0;
    end else if (wr) begin
      full <= 1'b1;
      dout <= din;
    end else if (take) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int PARITY_EN  = 1,
  parameter int PARITY_ODD = 0,
  parameter int STOP_BITS  = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 bit_stb,
  input  logic                 load,
  input  logic [DATA_BITS-1:0] din,
  output logic                 busy,
  output logic                 last,
  output logic                 sd
);
  localparam int FRAME_LEN = 1 + DATA_BITS + PARITY_EN + STOP_BITS;
  localparam int CW        = $clog2(FRAME_LEN + 1);

  // Bit 0 goes out first: start, data LSB first, parity, stops.
  function automatic logic [FRAME_LEN-1:0] make_frame(input logic [DATA_BITS-1:0] d);
    logic [FRAME_LEN-1:0] f;
    f = '1;
    f[0] = 1'b0;
    f[DATA_BITS:1] = d;
    if (PARITY_EN != 0)
      f[DATA_BITS+1] = par_bit(16'(d), DATA_BITS, PARITY_ODD != 0);
    return f;
  endfunction

  logic [FRAME_LEN-1:0] sr;
  logic [CW-1:0]        left;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      sr   <= '1;
      left <= '0;
      busy <= 1'b0;
    end else if (bit_stb) begin
      if (load) begin
        sr   <= make_frame(din);
        left <= CW'(FRAME_LEN);
        busy <= 1'b1;
      end else if (busy) begin
        sr   <= {1'b1, sr[FRAME_LEN-1:1]};
        left <= left - 1'b1;
        if (left == CW'(1)) busy <= 1'b0;
      end
    end
  end

  assign last = busy && (left == CW'(1));
  assign sd   = sr[0];
endmodule

// File: rtl/sertx_brk.sv
module sertx_brk #(
  parameter int DATA_BITS  = 8,
  parameter int PARITY_EN  = 1,
  parameter int PARITY_ODD = 0,
  parameter int STOP_BITS  = 1,
  parameter int OS_RATE    = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick16,
  input  logic                 wr_en,
  input  logic [DATA_BITS-1:0] wr_data,
  input  logic                 cmd_valid,
  input  logic                 cmd_enable,
  input  logic                 cmd_disable,
  input  logic                 cmd_reset,
  input  logic                 cmd_brk_start,
  input  logic                 cmd_brk_stop,
  output logic                 txd,
  output logic                 tx_ready,
  output logic                 tx_empty
);
  // Named internal events (also observed by the bound checker)
  logic bit_stb, brk_active;
  logic c_rst, c_dis, c_en, c_bs, c_be;
  logic drained, free_slot, wr_ok, hold_clr, load_go, brk_go, brk_end, dis_go;

  logic en_r, dis_pend, brk_pend, brk_on, stop_pend;
  logic                 hold_full;
  logic [DATA_BITS-1:0] hold_q;
  logic                 sh_busy, sh_last, sh_sd;

  sertx_bitclk #(.OS_RATE(OS_RATE)) u_bitclk (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .bit_stb(bit_stb)
  );

  sertx_hold #(.W(DATA_BITS)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr(wr_ok), .clr(hold_clr), .take(load_go),
    .din(wr_data), .full(hold_full), .dout(hold_q)
  );

  sertx_shift #(
    .DATA_BITS(DATA_BITS), .PARITY_EN(PARITY_EN),
    .PARITY_ODD(PARITY_ODD), .STOP_BITS(STOP_BITS)
  ) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(c_rst), .bit_stb(bit_stb), .load(load_go),
    .din(hold_q), .busy(sh_busy), .last(sh_last), .sd(sh_sd)
  );

  // Command decode: reset dominates, disable beats enable
  assign c_rst = cmd_valid && cmd_reset;
  assign c_dis = cmd_valid && cmd_disable && !c_rst;
  assign c_en  = cmd_valid && cmd_enable && !cmd_disable && !c_rst;
  assign c_bs  = cmd_valid && cmd_brk_start && !c_rst;
  assign c_be  = cmd_valid && cmd_brk_stop && !c_rst;

  assign drained   = !sh_busy && !hold_full;
  assign free_slot = !sh_busy || sh_last;
  assign tx_ready  = en_r && !dis_pend && !hold_full;
  assign tx_empty  = tx_ready && !sh_busy;

  assign wr_ok    = wr_en && tx_ready && !c_rst && !c_dis;
  assign hold_clr = c_rst || (c_en && !en_r);
  assign load_go  = bit_stb && free_slot && hold_full && en_r && !brk_on;
  assign brk_go   = bit_stb && brk_pend && free_slot && !hold_full && !dis_pend && !c_be;
  assign brk_end  = bit_stb && brk_on && stop_pend;
  assign dis_go   = dis_pend && drained;

  always_ff @(posedge clk) begin
    if (!rst_n || c_rst) begin
      en_r      <= 1'b0;
      dis_pend  <= 1'b0;
      brk_pend  <= 1'b0;
      brk_on    <= 1'b0;
      stop_pend <= 1'b0;
    end else begin
      if (c_dis) begin
        if (en_r && drained) en_r     <= 1'b0;
        else if (en_r)       dis_pend <= 1'b1;
      end else if (c_en) begin
        en_r     <= 1'b1;
        dis_pend <= 1'b0;
      end else if (dis_go) begin
        en_r     <= 1'b0;
        dis_pend <= 1'b0;
      end

      if (!en_r) begin
        brk_pend  <= 1'b0;
        brk_on    <= 1'b0;
        stop_pend <= 1'b0;
      end else begin
        if (brk_go) begin
          brk_pend <= 1'b0;
          brk_on   <= 1'b1;
        end else if (c_bs && !dis_pend && !brk_on) begin
          brk_pend <= 1'b1;
        end
        if (c_be) begin
          brk_pend <= 1'b0;
          if (brk_on) stop_pend <= 1'b1;
        end
        if (brk_end) begin
          brk_on    <= 1'b0;
          stop_pend <= 1'b0;
        end
      end
    end
  end

  assign brk_active = brk_on && en_r;
  assign txd        = brk_active ? 1'b0 : sh_sd;
endmodule

// File: rtl/sertx_brk_chk.sv
module sertx_brk_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_enable,
  input logic cmd_disable,
  input logic cmd_reset,
  input logic wr_en,
  input logic txd,
  input logic tx_ready,
  input logic tx_empty,
  input logic bit_stb,
  input logic brk_active
);
  logic gap;

  always_ff @(posedge clk) begin
    if (!rst_n)                                 gap <= 1'b0;
    else if (!brk_active && $past(brk_active))  gap <= 1'b1;
    else if (bit_stb)                           gap <= 1'b0;
  end

  // R11
  reset_cmd_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_reset |=> txd && !tx_ready && !tx_empty);

  // R4
  empty_implies_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> tx_ready);

  // R4
  write_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && tx_ready |=> !tx_ready);

  // R7
  en_dis_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_enable && cmd_disable |=> !tx_ready);

  // R12
  txd_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> $past(bit_stb || cmd_valid));

  // R10
  mark_after_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gap |-> txd);
endmodule

bind sertx_brk sertx_brk_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_enable(cmd_enable),
  .cmd_disable(cmd_disable), .cmd_reset(cmd_reset), .wr_en(wr_en), .txd(txd),
  .tx_ready(tx_ready), .tx_empty(tx_empty), .bit_stb(bit_stb), .brk_active(brk_active)
);

// File: tb/sertx_brk_tb.sv
`timescale 1ns/1ps
module sertx_brk_tb;
  localparam int BIT_CLKS = 32;   // 16 ticks, one tick every other clock

  logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic cmd_valid = 1'b0, cmd_enable = 1'b0, cmd_disable = 1'b0;
  logic cmd_reset = 1'b0, cmd_brk_start = 1'b0, cmd_brk_stop = 1'b0;
  logic txd, tx_ready, tx_empty;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  sertx_brk u_dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_en(wr_en), .wr_data(wr_data),
    .cmd_valid(cmd_valid), .cmd_enable(cmd_enable), .cmd_disable(cmd_disable),
    .cmd_reset(cmd_reset), .cmd_brk_start(cmd_brk_start), .cmd_brk_stop(cmd_brk_stop),
    .txd(txd), .tx_ready(tx_ready), .tx_empty(tx_empty)
  );

  always #2 clk = ~clk;

  initial forever begin
    @(negedge clk);
    tick16 = ~tick16;
  end

  // Independent bit-boundary tracking for R12
  int   tcnt = 0;
  logic stb_seen = 1'b0, cmd_seen = 1'b0, prev_txd = 1'b1;
  int   bad_edges = 0;
  always @(posedge clk) begin
    stb_seen <= rst_n && tick16 && (tcnt % 16 == 15);
    cmd_seen <= cmd_valid;
    if (!rst_n)      tcnt <= 0;
    else if (tick16) tcnt <= tcnt + 1;
  end
  always @(negedge clk) begin
    if (rst_n && (txd !== prev_txd) && !(stb_seen || cmd_seen)) bad_edges++;
    prev_txd <= txd;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_cmd(input bit en, input bit dis, input bit rst, input bit bs, input bit be);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_enable = en; cmd_disable = dis;
    cmd_reset = rst; cmd_brk_start = bs; cmd_brk_stop = be;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_enable = 1'b0; cmd_disable = 1'b0;
    cmd_reset = 1'b0; cmd_brk_start = 1'b0; cmd_brk_stop = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_level(input logic lvl, input int limit, output int n);
    n = 0;
    while (txd !== lvl && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic hold_level(input logic lvl, input int n, input string tag);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (txd !== lvl) bad++;
    end
    chk(bad == 0, tag, bad, 0);
  endtask

  // Called on the first low sample of a start bit; samples bit centres.
  task automatic rx_body(input logic [7:0] exp, input string tag);
    logic [7:0] d;
    logic st, p, s;
    repeat (15) @(negedge clk);
    st = txd;
    for (int i = 0; i < 8; i++) begin
      repeat (BIT_CLKS) @(negedge clk);
      d[i] = txd;
    end
    repeat (BIT_CLKS) @(negedge clk);
    p = txd;
    repeat (BIT_CLKS) @(negedge clk);
    s = txd;
    chk(st == 1'b0, {tag, " start"}, st, 0);
    chk(d == exp, {tag, " data"}, d, exp);
    chk(p == ^exp, {tag, " parity"}, p, ^exp);
    chk(s == 1'b1, {tag, " stop"}, s, 1);
  endtask

  task automatic rx_frame(input logic [7:0] exp, input string tag);
    int n;
    wait_level(1'b0, 4000, n);
    chk(txd == 1'b0, {tag, " start seen"}, txd, 0);
    rx_body(exp, tag);
  endtask

  task automatic t_reset_state();
    chk(txd == 1'b1, "R1 txd", txd, 1);
    chk(tx_ready == 1'b0, "R1 ready", tx_ready, 0);
    chk(tx_empty == 1'b0, "R1 empty", tx_empty, 0);
  endtask

  task automatic t_disabled_write();
    do_write(8'h3C);
    do_cmd(1, 0, 0, 0, 0);
    chk(tx_ready == 1'b1, "R3 ready on enable", tx_ready, 1);
    chk(tx_empty == 1'b1, "R3 empty on enable", tx_empty, 1);
    hold_level(1'b1, 12 * BIT_CLKS, "R3 disabled write dropped");
  endtask

  task automatic t_single();
    do_write(8'hA5);
    chk(tx_ready == 1'b0, "R4 ready cleared", tx_ready, 0);
    begin
      int n;
      wait_level(1'b0, 2 * BIT_CLKS, n);
      chk(n <= BIT_CLKS + 1, "R2 start within bit", n, BIT_CLKS);
      chk(tx_ready == 1'b1, "R4 ready on transfer", tx_ready, 1);
    end
    rx_body(8'hA5, "R2 single");
    repeat (20) @(negedge clk);
    chk(tx_empty == 1'b1, "R4 empty after stop", tx_empty, 1);
  endtask

  task automatic t_back_to_back();
    fork
      begin
        rx_frame(8'h5A, "R2 b2b first");
        rx_frame(8'hC3, "R2 b2b second");
      end
      begin
        do_write(8'h5A);
        do_write(8'hFF);
        while (!tx_ready) @(negedge clk);
        do_write(8'hC3);
      end
    join
    hold_level(1'b1, 3 * BIT_CLKS, "R5 ignored write not sent");
  endtask

  task automatic t_en_dis_clash();
    do_cmd(1, 1, 0, 0, 0);
    chk(tx_ready == 1'b0, "R7 clash from enabled", tx_ready, 0);
    do_cmd(1, 1, 0, 0, 0);
    chk(tx_ready == 1'b0, "R7 clash from disabled", tx_ready, 0);
    do_cmd(1, 0, 0, 0, 0);
  endtask

  task automatic t_defer_disable();
    fork
      rx_frame(8'h81, "R6 drained frame");
      begin
        do_write(8'h81);
        repeat (2) @(negedge clk);
        do_cmd(0, 1, 0, 0, 0);
        chk(tx_ready == 1'b0, "R6 ready cleared", tx_ready, 0);
        chk(tx_empty == 1'b0, "R6 empty cleared", tx_empty, 0);
      end
    join
    repeat (20) @(negedge clk);
    do_write(8'h22);
    chk(tx_ready == 1'b0, "R6 stays disabled", tx_ready, 0);
    hold_level(1'b1, 12 * BIT_CLKS, "R6 no send after disable");
    do_cmd(1, 0, 0, 0, 0);
  endtask

  task automatic t_break_idle();
    int n;
    do_cmd(0, 0, 0, 1, 0);
    wait_level(1'b0, 2 * BIT_CLKS, n);
    chk(n <= BIT_CLKS + 1, "R8 break begins", n, BIT_CLKS);
    hold_level(1'b0, 24 * BIT_CLKS, "R8 break held");
    do_write(8'h3E);
    chk(tx_ready == 1'b0, "R10 write held in break", tx_ready, 0);
    hold_level(1'b0, 2 * BIT_CLKS, "R10 no send in break");
    do_cmd(0, 0, 0, 0, 1);
    wait_level(1'b1, 2 * BIT_CLKS, n);
    chk(n <= BIT_CLKS + 1, "R10 break ends", n, BIT_CLKS);
    wait_level(1'b0, 4 * BIT_CLKS, n);
    chk(n >= BIT_CLKS - 1, "R10 mark gap", n, BIT_CLKS);
    rx_body(8'h3E, "R10 after break");
  endtask

  task automatic t_break_active();
    fork
      rx_frame(8'h69, "R9 frame before break");
      begin
        do_write(8'h69);
        do_cmd(0, 0, 0, 1, 0);
      end
    join
    repeat (18) @(negedge clk);
    chk(txd == 1'b0, "R9 break after stop", txd, 0);
    do_cmd(0, 0, 0, 0, 1);
    repeat (3 * BIT_CLKS) @(negedge clk);
    chk(txd == 1'b1, "R10 line back to mark", txd, 1);
  endtask

  task automatic t_break_disabled();
    do_cmd(0, 1, 0, 0, 0);
    do_cmd(0, 0, 0, 1, 0);
    hold_level(1'b1, 4 * BIT_CLKS, "R8 break refused while disabled");
    do_cmd(1, 0, 0, 0, 0);
    hold_level(1'b1, 4 * BIT_CLKS, "R8 no late break on enable");
  endtask

  task automatic t_reset_cmd();
    int n;
    do_write(8'h55);
    wait_level(1'b0, 2 * BIT_CLKS, n);
    repeat (40) @(negedge clk);
    do_write(8'h0F);
    do_cmd(0, 0, 1, 0, 0);
    chk(txd == 1'b1, "R11 txd mark", txd, 1);
    chk(tx_ready == 1'b0, "R11 ready cleared", tx_ready, 0);
    chk(tx_empty == 1'b0, "R11 empty cleared", tx_empty, 0);
    hold_level(1'b1, 12 * BIT_CLKS, "R11 stays quiet");
    do_cmd(1, 0, 0, 0, 0);
    chk(tx_empty == 1'b1, "R11 re-enable empty", tx_empty, 1);
    hold_level(1'b1, 12 * BIT_CLKS, "R11 held char discarded");
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset_state();
    t_disabled_write();
    t_single();
    t_back_to_back();
    t_en_dis_clash();
    t_defer_disable();
    t_break_idle();
    t_break_active();
    t_break_disabled();
    t_reset_cmd();
    chk(bad_edges == 0, "R12 txd edges on boundaries", bad_edges, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule